// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits beside the command sequencer of a parallel NOR flash model and produces what a host sees when it polls the device during a program or erase. The sequencer sends three kinds of start pulse: program (with bit 7 of the byte being written), sector erase and chip erase. It also sends a strobe for each status read and a slow timing tick. In return the block keeps an 8-bit polling status word, raises a busy flag for the length of the operation, and ends each operation with a one-cycle done pulse. The done pulse carries a flag that tells the sequencer where to go next: back to the bypass command state, or back to array-read mode.

The polling word follows the usual toggle and data-polling conventions. During a program, the top bit shows the complement of the top data bit. An erase clears the whole word, and the top bit flips when the erase finishes. Bit 6 flips on every status read, so a host that reads twice sees it change while the device is busy.

Programming finishes on the first tick after it starts. The two erase lengths are parameters counted in ticks, so a system can map them onto real times (for example, half a second and five seconds at a 1 ms tick) and a simulation can use short values.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, status is 0x00, and busy, done and to_bypass are all 0.
- R2: An accepted program start loads status with bit 7 equal to the inverse of prog_dq7 and bits 6..0 all 1, visible the cycle after the start.
- R3: An accepted sector-erase or chip-erase start clears status to 0x00, visible the cycle after the start.
- R4: Each cycle with status_rd high inverts status bit 6 at the following edge; the value presented during the read cycle is the value before the inversion.
- R5: When an erase completes, status bit 7 is inverted; when a program completes, status is left unchanged.
- R6: busy rises the cycle after an accepted start. Counting ticks from the cycle after the start, a program completes on tick 1, a sector erase on tick SECT_TICKS and a chip erase on tick CHIP_TICKS.
- R7: On the completing edge, busy falls and done goes high for exactly one cycle; busy never falls without done.
- R8: to_bypass is updated together with done to the value of bypass_active in the completing cycle, and holds it until the next completion.
- R9: A start pulse of any kind while busy is high is ignored: status keeps its value (apart from R4 and R5), and the running operation keeps its length.
- R10: Start pulses that arrive together in an idle cycle are resolved with chip erase first, then sector erase, then program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing tick that advances the operation counter |
| prog_start | input | 1 | Program start pulse |
| prog_dq7 | input | 1 | Bit 7 of the byte being programmed |
| sect_erase_start | input | 1 | Sector erase start pulse |
| chip_erase_start | input | 1 | Chip erase start pulse |
| status_rd | input | 1 | Status read strobe, one per read |
| bypass_active | input | 1 | Sequencer is in bypass mode |
| status | output | 8 | Polling status word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| to_bypass | output | 1 | With done: 1 means return to the bypass command state, 0 means return to array read |

## Verification
Programs are swept over both values of the data bit, both bypass settings, zero or one read before completion, and up to three idle cycles before the tick. This separates the loaded polling value from the read toggle, and shows that program length depends on ticks rather than cycles.

Both erase kinds are run with a tick every cycle, every second cycle and every third cycle, with and without interleaved reads. The measured tick count tells a counter that is off by one from a correct one, and the status checks tell bit 6 toggling apart from bit 7 flipping.

Starts injected during a running erase, and simultaneous starts in an idle cycle, show which operation owns the status word and the length of the operation.

// File: rtl/flash_poll_status_pkg.sv
package flash_poll_status_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_PROG = 2'd1,
        OPK_SECT = 2'd2,
        OPK_CHIP = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     dq7;
    } op_req_t;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    function automatic logic [7:0] prog_poll_word(input logic dq7);
        return {~dq7, 7'h7F};
    endfunction

    function automatic logic kind_is_erase(input op_kind_e k);
        return (k == OPK_SECT) || (k == OPK_CHIP);
    endfunction

endpackage

// File: rtl/fps_start_arb.sv
module fps_start_arb
    import flash_poll_status_pkg::*;
(
    input  logic    busy,
    input  logic    prog_start,
    input  logic    prog_dq7,
    input  logic    sect_start,
    input  logic    chip_start,
    output op_req_t req
);
    always_comb begin
        req.dq7  = prog_dq7;
        req.kind = OPK_NONE;
        if (!busy) begin
            if (chip_start)      req.kind = OPK_CHIP;
            else if (sect_start) req.kind = OPK_SECT;
            else if (prog_start) req.kind = OPK_PROG;
        end
    end
endmodule

// File: rtl/fps_op_timer.sv
module fps_op_timer
    import flash_poll_status_pkg::*;
#(
    parameter int SECT_TICKS = 500,
    parameter int CHIP_TICKS = 5000,
    parameter int CNT_W      = 13
) (
    input  logic    clk,
    input  logic    rst,
    input  op_req_t req,
    input  logic    tick,
    output logic    busy,
    output logic    complete,
    output logic    erase_run
);
    localparam logic [CNT_W-1:0] SECT_LOAD = CNT_W'(SECT_TICKS - 1);
    localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_TICKS - 1);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;
    logic             busy_q;
    logic             erase_q;

    always_comb begin
        case (req.kind)
            OPK_SECT: load_val = SECT_LOAD;
            OPK_CHIP: load_val = CHIP_LOAD;
            default:  load_val = '0;
        endcase
    end

    assign complete  = busy_q && tick && (remain_q == '0);
    assign busy      = busy_q;
    assign erase_run = erase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            erase_q  <= 1'b0;
            remain_q <= '0;
        end else if (req.kind != OPK_NONE) begin
            busy_q   <= 1'b1;
            erase_q  <= kind_is_erase(req.kind);
            remain_q <= load_val;
        end else if (busy_q && tick) begin
            if (remain_q == '0) busy_q   <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/fps_status_reg.sv
module fps_status_reg
    import flash_poll_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_req_t    req,
    input  logic       status_rd,
    input  logic       erase_done,
    output logic [7:0] status
);
    logic [7:0] stat_q;
    logic [7:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        case (req.kind)
            OPK_PROG: stat_d = prog_poll_word(req.dq7);
            OPK_SECT,
            OPK_CHIP: stat_d = 8'h00;
            default: begin
                if (status_rd)  stat_d[TOGGLE_BIT] = ~stat_q[TOGGLE_BIT];
                if (erase_done) stat_d[POLL_BIT]   = ~stat_q[POLL_BIT];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 8'h00;
        else     stat_q <= stat_d;
    end

    assign status = stat_q;
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_status_pkg::*;
#(
    parameter int SECT_TICKS = 500,
    parameter int CHIP_TICKS = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       prog_start,
    input  logic       prog_dq7,
    input  logic       sect_erase_start,
    input  logic       chip_erase_start,
    input  logic       status_rd,
    input  logic       bypass_active,
    output logic [7:0] status,
    output logic       busy,
    output logic       done,
    output logic       to_bypass
);
    localparam int MAX_TICKS = (SECT_TICKS > CHIP_TICKS) ? SECT_TICKS : CHIP_TICKS;
    localparam int CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);

    op_req_t req;
    logic    busy_w;
    logic    complete;
    logic    erase_run;
    logic    done_q;
    logic    byp_q;

    fps_start_arb u_arb (
        .busy       (busy_w),
        .prog_start (prog_start),
        .prog_dq7   (prog_dq7),
        .sect_start (sect_erase_start),
        .chip_start (chip_erase_start),
        .req        (req)
    );

    fps_op_timer #(
        .SECT_TICKS (SECT_TICKS),
        .CHIP_TICKS (CHIP_TICKS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .tick      (tick),
        .busy      (busy_w),
        .complete  (complete),
        .erase_run (erase_run)
    );

    fps_status_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .status_rd  (status_rd),
        .erase_done (complete && erase_run),
        .status     (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            byp_q  <= 1'b0;
        end else begin
            done_q <= complete;
            if (complete) byp_q <= bypass_active;
        end
    end

    assign busy      = busy_w;
    assign done      = done_q;
    assign to_bypass = byp_q;
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       prog_start,
    input logic       prog_dq7,
    input logic       sect_erase_start,
    input logic       chip_erase_start,
    input logic       status_rd,
    input logic [7:0] status,
    input logic       busy,
    input logic       done
);
    logic any_start;
    logic erase_start;
    assign erase_start = sect_erase_start || chip_erase_start;
    assign any_start   = erase_start || prog_start;

    AST_PROG_POLL_WORD: assert property (@(posedge clk) disable iff (rst)
        (!busy && prog_start && !erase_start) |=> (status == {~$past(prog_dq7), 7'h7F})); // R2

    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!busy && erase_start) |=> (status == 8'h00)); // R3

    AST_READ_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (status_rd && (busy || !any_start)) |=> (status[6] != $past(status[6]))); // R4

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && any_start) |=> busy); // R6

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && any_start && !status_rd) |=> (status[6:0] == $past(status[6:0]))); // R9
endmodule

bind flash_poll_status flash_poll_status_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .prog_start       (prog_start),
    .prog_dq7         (prog_dq7),
    .sect_erase_start (sect_erase_start),
    .chip_erase_start (chip_erase_start),
    .status_rd        (status_rd),
    .status           (status),
    .busy             (busy),
    .done             (done)
);

// File: tb/flash_poll_status_test.sv
`timescale 1ns/100ps
module flash_poll_status_test;
    localparam int ST = 5;
    localparam int CT = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, prog_start = 1'b0, prog_dq7 = 1'b0;
    logic sect_erase_start = 1'b0, chip_erase_start = 1'b0;
    logic status_rd = 1'b0, bypass_active = 1'b0;
    logic [7:0] status;
    logic busy, done, to_bypass;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_st;

    always #2.5 clk = ~clk;

    flash_poll_status #(.SECT_TICKS(ST), .CHIP_TICKS(CT)) uut (
        .clk(clk), .rst(rst), .tick(tick), .prog_start(prog_start),
        .prog_dq7(prog_dq7), .sect_erase_start(sect_erase_start),
        .chip_erase_start(chip_erase_start), .status_rd(status_rd),
        .bypass_active(bypass_active), .status(status), .busy(busy),
        .done(done), .to_bypass(to_bypass)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ps, input logic d7, input logic se, input logic ce,
                        input logic t, input logic rd);
        @(negedge clk);
        prog_start = ps; prog_dq7 = d7; sect_erase_start = se;
        chip_erase_start = ce; tick = t; status_rd = rd;
        @(posedge clk);
        #1;
        prog_start = 0; sect_erase_start = 0; chip_erase_start = 0;
        tick = 0; status_rd = 0;
    endtask

    // Erase-style run: start with given pulses, then count ticks to done.
    task automatic run_erase(input logic ps, input logic se, input logic ce,
                             input int n_exp, input int period, input int inject_at,
                             input logic reads, input string tag);
        int ticks = 0;
        step(ps, 1'b0, se, ce, 1'b0, 1'b0);
        exp_st = 8'h00;
        chk({tag, " R3 R10 cleared"}, status, exp_st);
        chk({tag, " R6 busy rise"}, {7'd0, busy}, 8'd1);
        for (int c = 0; c < 200; c++) begin
            logic t, rd, inj;
            t   = ((c % period) == period - 1);
            rd  = reads && ((c % 3) == 1);
            inj = (c == inject_at);
            step(inj, 1'b0, 1'b0, inj, t, rd);
            if (rd) exp_st[6] = ~exp_st[6];
            if (t) ticks++;
            if (ticks == n_exp) begin
                exp_st[7] = ~exp_st[7];
                chk({tag, " R6 R7 done at tick count"}, {7'd0, done}, 8'd1);
                chk({tag, " R7 busy fell"}, {7'd0, busy}, 8'd0);
                chk({tag, " R5 R4 R9 status at end"}, status, exp_st);
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
                chk({tag, " R7 done single"}, {7'd0, done}, 8'd0);
                return;
            end
            chk({tag, " R6 R9 still busy"}, {6'd0, busy, done}, 8'd2);
            chk({tag, " R4 R9 status while busy"}, status, exp_st);
        end
        chk({tag, " R6 no completion"}, 8'd0, 8'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset flags", {5'd0, busy, done, to_bypass}, 8'd0);

        // Idle reads toggle bit 6
        exp_st = 8'h00;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            exp_st[6] = ~exp_st[6];
            chk("R4 idle read toggle", status, exp_st);
        end

        // Program sweep
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < 2; r++)
                    for (int w = 0; w < 4; w++) begin
                        bypass_active = b[0];
                        step(1'b1, d[0], 1'b0, 1'b0, 1'b1, 1'b0);
                        exp_st = {~d[0], 7'h7F};
                        chk("R2 program poll word", status, exp_st);
                        chk("R6 program busy", {6'd0, busy, done}, 8'd2);
                        if (r == 1) begin
                            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
                            exp_st[6] = ~exp_st[6];
                            chk("R4 read during program", status, exp_st);
                        end
                        for (int k = 0; k < w; k++) begin
                            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
                            chk("R6 program waits for tick", {7'd0, busy}, 8'd1);
                        end
                        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                        chk("R6 R7 program done", {6'd0, busy, done}, 8'd1);
                        chk("R8 return target", {7'd0, to_bypass}, {7'd0, b[0]});
                        chk("R5 program end keeps status", status, exp_st);
                        bypass_active = ~b[0];
                        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                        chk("R7 R8 done drops, target held", {6'd0, done, to_bypass},
                            {7'd0, b[0]});
                    end

        // Erase runs over tick periods, with and without reads
        for (int p = 1; p <= 3; p++)
            for (int r = 0; r < 2; r++) begin
                run_erase(1'b0, 1'b1, 1'b0, ST, p, -1, r[0], "sector");
                run_erase(1'b0, 1'b0, 1'b1, CT, p, -1, r[0], "chip");
            end

        // Starts while busy are ignored
        run_erase(1'b0, 1'b1, 1'b0, ST, 2, 3, 1'b0, "R9 inject in sector");
        run_erase(1'b0, 1'b1, 1'b0, ST, 1, 1, 1'b1, "R9 inject with read");

        // Simultaneous starts
        run_erase(1'b1, 1'b1, 1'b1, CT, 1, -1, 1'b0, "R10 all three");
        run_erase(1'b1, 1'b1, 1'b0, ST, 1, -1, 1'b0, "R10 sector over program");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule